// File: doc/BRIEF.md
# Predicated Integer ALU with Status Flags

This block is the integer execute stage of a small processor core. Each cycle it takes two 32-bit operands (the second one already shifted or rotated upstream), the carry produced by that shifter, a 4-bit operation select, a flag-update request and a 4-bit predicate. It produces the result, a write enable for the destination register, the status flags that will be in force after this operation, and whether the predicate held.

The status flags (negative, zero, carry, overflow) live in a register inside the block. The predicate is tested against that register. When the predicate fails, the operation is squashed: nothing is written and the flags keep their value. Four of the sixteen operations are compare and test forms. They set the flags and never write a register.

Top module: `cond_alu`

## Requirements
- R1: For the logical opcodes 0, 1, 12, 13, 14 and 15, `result` is A AND B, A XOR B, A OR B, B, A AND NOT B and NOT B, in that order. `reg_wr_en` is 1 whenever the predicate passes.
- R2: With C the current carry flag, the arithmetic opcodes 2 to 7 give A−B, B−A, A+B, A+B+C, A−B+C−1 and B−A+C−1, in that order, all modulo 2^32.
- R3: Opcodes 8, 9, 10 and 11 compute as opcodes 0, 1, 2 and 4. They never raise `reg_wr_en`. When the predicate passes they update the flags, whatever `set_flags` holds.
- R4: The flags use the layout {N,Z,C,V}, with N in bit 3. When flags update, N equals `result` bit 31, and Z is 1 exactly when `result` is zero.
- R5: For arithmetic opcodes that update flags, C is the unsigned carry out of the addition. For subtractions this means C is 1 when no borrow occurs. V is 1 when the exact signed result does not fit in 32 bits.
- R6: For logical opcodes that update flags, C takes `shift_carry` and V keeps its previous value.
- R7: A passing non-test opcode with `set_flags` at 0 leaves all four flags unchanged.
- R8: The predicate codes 0 to 14 pass, in this order, on: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), Z|(N!=V), and always.
- R9: Predicate code 15 never passes.
- R10: When the predicate fails, `reg_wr_en` is 0 and `flags_next` equals `flags`.
- R11: `flags` loads `flags_next` on every rising clock edge. A synchronous low `rst_n` clears `flags` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, after the shifter |
| shift_carry | input | 1 | Carry out of the shifter |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update |
| cond_code | input | 4 | Predicate select |
| result | output | 32 | Operation result |
| reg_wr_en | output | 1 | Destination register write enable |
| flags_next | output | 4 | Flags after this operation {N,Z,C,V} |
| flags | output | 4 | Registered current flags {N,Z,C,V} |
| cond_pass | output | 1 | Predicate held |

## Verification
Some rules are checked on every cycle by assertions: test opcodes never write, and a failed predicate holds the flags. Other per-cycle rules are also asserted: a logical opcode preserves V, a passing op with no flag request leaves all flags unchanged, and the always and never predicates behave as stated. The numerical content can only be shown by the bench's reference model over directed and random operands. That covers the arithmetic results, the carry and overflow values at the signed and unsigned boundaries, and each predicate decoding against hand-built flag states.

// File: rtl/cond_alu_pkg.sv
// Shared types for the predicated ALU: operation and predicate encodings,
// flag layout and opcode class helpers. Encodings are fixed by the decoder.
package cond_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND   = 4'd0,  OP_XOR   = 4'd1,  OP_SUB   = 4'd2,  OP_RSUB  = 4'd3,
        OP_ADD   = 4'd4,  OP_ADDC  = 4'd5,  OP_SUBC  = 4'd6,  OP_RSUBC = 4'd7,
        OP_TAND  = 4'd8,  OP_TXOR  = 4'd9,  OP_TSUB  = 4'd10, OP_TADD  = 4'd11,
        OP_OR    = 4'd12, OP_MOVE  = 4'd13, OP_CLR   = 4'd14, OP_NMOVE = 4'd15
    } alu_op_e;

    typedef enum logic [3:0] {
        CND_ZSET = 4'd0,  CND_ZCLR = 4'd1,  CND_CSET = 4'd2,  CND_CCLR = 4'd3,
        CND_NSET = 4'd4,  CND_NCLR = 4'd5,  CND_VSET = 4'd6,  CND_VCLR = 4'd7,
        CND_UGT  = 4'd8,  CND_ULE  = 4'd9,  CND_SGE  = 4'd10, CND_SLT  = 4'd11,
        CND_SGT  = 4'd12, CND_SLE  = 4'd13, CND_ALWAYS = 4'd14, CND_NEVER = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Compare/test class: flags only, no register write.
    function automatic logic op_is_test(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    // Logical class: carry from shifter, overflow preserved.
    function automatic logic op_is_logic(input logic [3:0] op);
        case (op)
            OP_AND, OP_XOR, OP_TAND, OP_TXOR,
            OP_OR, OP_MOVE, OP_CLR, OP_NMOVE: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_cond_eval.sv
// Predicate evaluator: decides from the current flags whether the
// operation in this cycle takes effect. Purely combinational.
module alu_cond_eval
    import cond_alu_pkg::*;
(
    input  logic [3:0] cond,
    input  nzcv_t      flg,
    output logic       pass
);

    // Decode the predicate against the flags.
    always_comb begin
        case (cond_e'(cond))
            CND_ZSET:   pass = flg.z;
            CND_ZCLR:   pass = !flg.z;
            CND_CSET:   pass = flg.c;
            CND_CCLR:   pass = !flg.c;
            CND_NSET:   pass = flg.n;
            CND_NCLR:   pass = !flg.n;
            CND_VSET:   pass = flg.v;
            CND_VCLR:   pass = !flg.v;
            CND_UGT:    pass = flg.c && !flg.z;
            CND_ULE:    pass = !flg.c || flg.z;
            CND_SGE:    pass = flg.n == flg.v;
            CND_SLT:    pass = flg.n != flg.v;
            CND_SGT:    pass = !flg.z && (flg.n == flg.v);
            CND_SLE:    pass = flg.z || (flg.n != flg.v);
            CND_ALWAYS: pass = 1'b1;
            default:    pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_datapath.sv
// Datapath: one shared adder for all six arithmetic forms plus the
// bitwise unit. Subtraction is addition of the inverted operand with a
// carry-in. Assumes the second operand is already shifted upstream.
module alu_datapath
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf
);

    localparam int SW = W + 1;

    logic [W-1:0]  add_x, add_y;
    logic          add_ci;
    logic [SW-1:0] sum;

    // Pick adder operands and carry-in for each arithmetic form.
    always_comb begin
        add_x  = a;
        add_y  = b;
        add_ci = 1'b0;
        case (alu_op_e'(op))
            OP_SUB, OP_TSUB: begin add_y = ~b; add_ci = 1'b1; end
            OP_RSUB:         begin add_x = b;  add_y = ~a; add_ci = 1'b1; end
            OP_ADDC:         begin add_ci = cin; end
            OP_SUBC:         begin add_y = ~b; add_ci = cin; end
            OP_RSUBC:        begin add_x = b;  add_y = ~a; add_ci = cin; end
            default:         ;
        endcase
    end

    assign sum  = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
    assign cout = sum[W];
    assign ovf  = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);

    // Select the final result by opcode.
    always_comb begin
        case (alu_op_e'(op))
            OP_AND, OP_TAND: res = a & b;
            OP_XOR, OP_TXOR: res = a ^ b;
            OP_OR:           res = a | b;
            OP_MOVE:         res = b;
            OP_CLR:          res = a & ~b;
            OP_NMOVE:        res = ~b;
            default:         res = sum[W-1:0];
        endcase
    end

endmodule

// File: rtl/alu_flag_merge.sv
// Flag merge: forms the next flag value and the register write enable
// from the predicate outcome, the opcode class and the datapath outputs.
module alu_flag_merge
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         pass,
    input  logic         set_req,
    input  logic [3:0]   op,
    input  logic [W-1:0] res,
    input  logic         add_c,
    input  logic         add_v,
    input  logic         shf_c,
    input  nzcv_t        cur,
    output nzcv_t        nxt,
    output logic         wr_en
);

    logic upd;

    assign upd   = pass && (set_req || op_is_test(op));
    assign wr_en = pass && !op_is_test(op);

    // Build the next flags, holding any flag that is not updated.
    always_comb begin
        nxt = cur;
        if (upd) begin
            nxt.n = res[W-1];
            nxt.z = (res == '0);
            if (op_is_logic(op)) begin
                nxt.c = shf_c;
            end else begin
                nxt.c = add_c;
                nxt.v = add_v;
            end
        end
    end

endmodule

// File: rtl/cond_alu.sv
// Predicated ALU top: evaluates the predicate against the flag register,
// runs the datapath, merges flags and registers them every clock.
// Assumes operands are stable for the cycle; reset is synchronous, active low.
module cond_alu
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         shift_carry,
    input  logic [3:0]   opcode,
    input  logic         set_flags,
    input  logic [3:0]   cond_code,
    output logic [W-1:0] result,
    output logic         reg_wr_en,
    output logic [3:0]   flags_next,
    output logic [3:0]   flags,
    output logic         cond_pass
);

    nzcv_t flg_q, flg_d;
    logic  dp_c, dp_v;

    alu_cond_eval u_cond (
        .cond (cond_code),
        .flg  (flg_q),
        .pass (cond_pass)
    );

    alu_datapath #(.W(W)) u_dp (
        .op   (opcode),
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (flg_q.c),
        .res  (result),
        .cout (dp_c),
        .ovf  (dp_v)
    );

    alu_flag_merge #(.W(W)) u_merge (
        .pass    (cond_pass),
        .set_req (set_flags),
        .op      (opcode),
        .res     (result),
        .add_c   (dp_c),
        .add_v   (dp_v),
        .shf_c   (shift_carry),
        .cur     (flg_q),
        .nxt     (flg_d),
        .wr_en   (reg_wr_en)
    );

    // Flag register: cleared by reset, otherwise loads the merged value.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags      = flg_q;
    assign flags_next = flg_d;

    // R3
    test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] == 2'b10) |-> !reg_wr_en);

    // R10
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pass |=> flags == $past(flags));

    // R6
    logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_pass && op_is_logic(opcode)) |=> flags[0] == $past(flags[0]));

    // R7
    quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_pass && !set_flags && opcode[3:2] != 2'b10) |=> $stable(flags));

    // R9
    never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd15) |-> !cond_pass);

    // R8
    always_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd14) |-> cond_pass);

endmodule

// File: tb/cond_alu_test.sv
module cond_alu_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        shift_carry = 1'b0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [3:0]  cond_code = 4'd15;
    logic [31:0] result;
    logic        reg_wr_en;
    logic [3:0]  flags_next, flags;
    logic        cond_pass;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [3:0] mflags = 4'h0;   // model flags {N,Z,C,V}

    cond_alu uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_carry(shift_carry), .opcode(opcode), .set_flags(set_flags),
        .cond_code(cond_code), .result(result), .reg_wr_en(reg_wr_en),
        .flags_next(flags_next), .flags(flags), .cond_pass(cond_pass)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit model_pass(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            0: return z;              1: return !z;
            2: return cy;             3: return !cy;
            4: return n;              5: return !n;
            6: return v;              7: return !v;
            8: return cy && !z;       9: return !cy || z;
            10: return n == v;        11: return n != v;
            12: return !z && n == v;  13: return z || n != v;
            14: return 1;             default: return 0;
        endcase
    endfunction

    // Drive one vector, compare all outputs against the model, then clock.
    task automatic step(input logic [31:0] a, input logic [31:0] b,
                        input logic sc, input logic [3:0] op,
                        input logic s, input logic [3:0] c);
        longint ua, ub, sa, sb, ue, se;
        longint cin;
        logic [31:0] er;
        logic [3:0]  ef;
        bit p, tst, lgc, upd, ec, ev;
        string rtag, ftag;
        @(negedge clk);
        opnd_a = a; opnd_b = b; shift_carry = sc;
        opcode = op; set_flags = s; cond_code = c;
        #1;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        cin = longint'(mflags[1]);
        tst = (op >= 8 && op <= 11);
        lgc = (op inside {0, 1, 8, 9, 12, 13, 14, 15});
        ue = 0; se = 0; ec = 0;
        case (op)
            0, 8:  er = a & b;
            1, 9:  er = a ^ b;
            12:    er = a | b;
            13:    er = b;
            14:    er = a & ~b;
            15:    er = ~b;
            2, 10: begin ue = ua - ub; se = sa - sb; end
            3:     begin ue = ub - ua; se = sb - sa; end
            4, 11: begin ue = ua + ub; se = sa + sb; end
            5:     begin ue = ua + ub + cin; se = sa + sb + cin; end
            6:     begin ue = ua - ub + cin - 1; se = sa - sb + cin - 1; end
            default: begin ue = ub - ua + cin - 1; se = sb - sa + cin - 1; end
        endcase
        if (!lgc) begin
            er = ue[31:0];
            if (op == 4 || op == 5 || op == 11) ec = (ue >= 64'sh1_0000_0000);
            else                                ec = (ue >= 0);
        end
        ev = !lgc && (se != longint'($signed(er)));
        p   = model_pass(c, mflags);
        upd = p && (s || tst);
        ef  = mflags;
        if (upd) begin
            ef[3] = er[31];
            ef[2] = (er == 0);
            ef[1] = lgc ? sc : ec;
            if (!lgc) ef[0] = ev;
        end
        rtag = tst ? "R3" : (lgc ? "R1" : "R2");
        chk(rtag, "result", result, er);
        chk(c == 15 ? "R9" : "R8", "cond_pass", {31'd0, cond_pass}, {31'd0, p});
        chk(!p ? "R10" : (tst ? "R3" : "R1"), "reg_wr_en",
            {31'd0, reg_wr_en}, {31'd0, p && !tst});
        ftag = !p ? "R10" : (!upd ? "R7" : "R4");
        chk(ftag, "flags_next NZ", {30'd0, flags_next[3:2]}, {30'd0, ef[3:2]});
        ftag = !p ? "R10" : (!upd ? "R7" : (lgc ? "R6" : "R5"));
        chk(ftag, "flags_next CV", {30'd0, flags_next[1:0]}, {30'd0, ef[1:0]});
        chk("R11", "flags", {28'd0, flags}, {28'd0, mflags});
        @(posedge clk);
        mflags = ef;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 6)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "flags in reset", {28'd0, flags}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        mflags = 4'h0;
        // R6: logical set with shifter carry 0, N becomes 1, V stays 0
        step(32'h0, 32'h8000_0000, 1'b0, 4'd13, 1'b1, 4'd14);
        // R8: !V passes while N=1, V=0; V set fails
        step(32'h1, 32'h2, 1'b0, 4'd4, 1'b1, 4'd7);
        step(32'h5, 32'h5, 1'b0, 4'd2, 1'b1, 4'd6);
        // R3/R5: compare equal with set_flags=0 -> Z=1, C=1
        step(32'd5, 32'd5, 1'b0, 4'd10, 1'b0, 4'd14);
        // R5: signed overflow on add
        step(32'h7FFF_FFFF, 32'h1, 1'b0, 4'd4, 1'b1, 4'd14);
        // R6: logical keeps V=1, takes shifter carry 1
        step(32'hF0, 32'h0F, 1'b1, 4'd0, 1'b1, 4'd14);
        // R7: no flag request leaves flags
        step(32'h1, 32'hFFFF_FFFF, 1'b0, 4'd4, 1'b0, 4'd14);
        // R5: borrow on subtract -> C=0
        step(32'd3, 32'd4, 1'b0, 4'd2, 1'b1, 4'd14);
        // R2: subtract/reverse with carry using C=0
        step(32'd10, 32'd3, 1'b0, 4'd6, 1'b0, 4'd14);
        step(32'd10, 32'd3, 1'b0, 4'd7, 1'b1, 4'd14);
        // R9/R10: never code and failing code
        step(32'h1, 32'h1, 1'b1, 4'd4, 1'b1, 4'd15);
        for (int k = 0; k < 16; k++)
            step(pick(), pick(), 1'($urandom), 4'(k), 1'b1, 4'd14);
        for (int k = 0; k < 4000; k++)
            step(pick(), pick(), 1'($urandom), 4'($urandom),
                 1'($urandom), ($urandom % 4 == 0) ? 4'd14 : 4'($urandom));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule